// File: doc/BRIEF.md
# Operand Shifter With Carry Out

This block reshapes the second operand of an ALU before it reaches the adder or the logic unit. A 32-bit operand, a 3-bit shift-kind code, a 5-bit distance and the current carry flag go in. The shifted operand and the carry flag that a flag-setting operation would record come out. There is no clock and no state: both outputs depend only on the present inputs.

Every shift kind runs through one shared cascade of 2-to-1 multiplexer stages. Each stage is steered by one bit of the distance and moves data by a power of two. Right shifts and rotates use the cascade directly. A left shift reverses the bit order of the operand, goes through the same right-moving cascade, and is reversed back. The carry flag is taken from the last bit that leaves the word. Software that wants a left rotate by k asks for a right rotate by 32 − k.

Top module: `operand_shifter`

## Requirements
- R1: Kind code 0 (left shift) gives the operand moved toward the MSB by n places, with the n low bits set to zero.
- R2: Kind code 1 (logical right shift) gives the operand moved toward the LSB by n places, with the n high bits set to zero.
- R3: Kind code 2 (arithmetic right shift) gives the operand moved toward the LSB by n places, with the n high bits equal to operand bit 31.
- R4: Kind code 3 (right rotate) sets output bit i to operand bit (i+n) mod 32, so no bit is lost. A left rotate by k equals a right rotate by 32−k.
- R5: Kind code 4 (one-place rotate through carry) gives {carry_in, operand[31:1]} with carry_out = operand[0], whatever the distance input holds.
- R6: For kinds 0 to 3 with n > 0, carry_out is the last bit shifted out: operand[32−n] for kind 0, and operand[n−1] for kinds 1, 2 and 3.
- R7: For kinds 0 to 3 with n = 0, the operand passes through unchanged and carry_out equals carry_in.
- R8: Kind codes 5, 6 and 7 pass the operand through unchanged and give carry_out = carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_in | input | 32 | Operand to be shifted |
| shift_kind | input | 3 | Kind code: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry |
| shift_amt | input | 5 | Shift distance n (ignored by kind 4) |
| carry_in | input | 1 | Current carry flag |
| opnd_out | output | 32 | Shifted operand |
| carry_out | output | 1 | Carry flag produced by the shift |

## Verification
Random operands are applied with every kind code and all 32 distances. Each case is compared with a reference built from plain shift operators in the bench. Across the full distance range this shows whether each cascade stage moves data by the right power of two, and whether vacated bits take zero, the sign bit or the wrapped bits. Directed cases cover the ends of the distance range: a distance of 31 on a negative operand, a distance of 1 that pushes the MSB or the LSB out, and a rotate used as a left rotate. These cases separate a carry taken from the wrong end of the word from a correct one. The rotate-through-carry case is run with two different distances and with both carry values, to show that the distance is ignored and that carry_in lands in bit 31.

// File: rtl/shifter_pkg.sv
// Package: shift-kind encoding shared by the shifter, its checker and its bench.
package shifter_pkg;
    typedef enum logic [2:0] {
        SHK_LSL = 3'd0,
        SHK_LSR = 3'd1,
        SHK_ASR = 3'd2,
        SHK_ROR = 3'd3,
        SHK_RRX = 3'd4
    } shift_kind_e;
endpackage

// File: rtl/shift_bit_reverse.sv
// Module: shift_bit_reverse
// Mirrors a word end for end (bit i goes to bit WIDTH-1-i). Pure wiring.
// Assumes nothing about the data; used on both sides of the cascade for left shifts.
module shift_bit_reverse #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_in,
    output logic [WIDTH-1:0] word_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign word_out[i] = word_in[WIDTH-1-i];
    end
endmodule

// File: rtl/shift_mux_stage.sv
// Module: shift_mux_stage
// One cascade stage: when take is high every bit moves DIST places toward the
// LSB. Bits entering at the top wrap from the low end (wrap high) or take fill_bit.
// Assumes 0 < DIST < WIDTH.
module shift_mux_stage #(
    parameter int WIDTH = 32,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] stage_in,
    input  logic             take,
    input  logic             wrap,
    input  logic             fill_bit,
    output logic [WIDTH-1:0] stage_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic src;
        if (i + DIST < WIDTH) begin : g_inside
            assign src = stage_in[i+DIST];
        end else begin : g_edge
            assign src = wrap ? stage_in[i+DIST-WIDTH] : fill_bit;
        end
        assign stage_out[i] = take ? src : stage_in[i];
    end
endmodule

// File: rtl/shift_carry_select.sv
// Module: shift_carry_select
// Chooses the carry flag. oriented is the operand already mirrored for left
// shifts, so the last bit out is oriented[n-1] for every counted kind.
// Assumes AMT_W = clog2(WIDTH).
module shift_carry_select
    import shifter_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] oriented,
    input  logic [AMT_W-1:0] amt,
    input  logic [2:0]       kind,
    input  logic             cin,
    input  logic             lsb_in,
    output logic             cout
);
    logic [AMT_W-1:0] last_idx;
    assign last_idx = amt - AMT_W'(1);

    // Carry choice per kind, zero distance and the through-carry rotate.
    always_comb begin
        unique case (kind)
            SHK_LSL, SHK_LSR, SHK_ASR, SHK_ROR:
                cout = (amt == '0) ? cin : oriented[last_idx];
            SHK_RRX: cout = lsb_in;
            default: cout = cin;
        endcase
    end
endmodule

// File: rtl/operand_shifter.sv
// Module: operand_shifter (top)
// Combinational operand shifter for an ALU's second input. Five kinds share one
// log-depth right-moving multiplexer cascade; left shifts mirror the word
// around it. Assumes WIDTH is a power of two; there is no clock or state.
module operand_shifter
    import shifter_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_in,
    input  logic [2:0]       shift_kind,
    input  logic [AMT_W-1:0] shift_amt,
    input  logic             carry_in,
    output logic [WIDTH-1:0] opnd_out,
    output logic             carry_out
);
    localparam int STAGES = AMT_W;

    logic [WIDTH-1:0] mirrored_in;
    logic [WIDTH-1:0] oriented;
    logic [WIDTH-1:0] chain [0:STAGES];
    logic [WIDTH-1:0] mirrored_out;
    logic             is_left;
    logic             do_wrap;
    logic             fill_val;

    assign is_left  = (shift_kind == SHK_LSL);
    assign do_wrap  = (shift_kind == SHK_ROR);
    assign fill_val = (shift_kind == SHK_ASR) ? opnd_in[WIDTH-1] : 1'b0;

    shift_bit_reverse #(.WIDTH(WIDTH)) u_rev_in (
        .word_in  (opnd_in),
        .word_out (mirrored_in)
    );

    assign oriented = is_left ? mirrored_in : opnd_in;
    assign chain[0] = oriented;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        shift_mux_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
            .stage_in  (chain[k]),
            .take      (shift_amt[k]),
            .wrap      (do_wrap),
            .fill_bit  (fill_val),
            .stage_out (chain[k+1])
        );
    end

    shift_bit_reverse #(.WIDTH(WIDTH)) u_rev_out (
        .word_in  (chain[STAGES]),
        .word_out (mirrored_out)
    );

    // Result selection per kind; unknown codes pass the operand through.
    always_comb begin
        unique case (shift_kind)
            SHK_LSL:                   opnd_out = mirrored_out;
            SHK_LSR, SHK_ASR, SHK_ROR: opnd_out = chain[STAGES];
            SHK_RRX:                   opnd_out = {carry_in, opnd_in[WIDTH-1:1]};
            default:                   opnd_out = opnd_in;
        endcase
    end

    shift_carry_select #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_carry (
        .oriented (oriented),
        .amt      (shift_amt),
        .kind     (shift_kind),
        .cin      (carry_in),
        .lsb_in   (opnd_in[0]),
        .cout     (carry_out)
    );
endmodule

// File: rtl/operand_shifter_checker.sv
// Module: operand_shifter_checker
// Port-level properties of the shifter, bound to every operand_shifter.
// Assumes inputs are known whenever the checks are evaluated.
module operand_shifter_checker
    import shifter_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] opnd_in,
    input logic [2:0]       shift_kind,
    input logic [AMT_W-1:0] shift_amt,
    input logic             carry_in,
    input logic [WIDTH-1:0] opnd_out,
    input logic             carry_out
);
    // Immediate checks on every input change once inputs are known.
    always_comb begin
        if (!$isunknown({opnd_in, shift_kind, shift_amt, carry_in})) begin
            if (shift_kind == SHK_LSL && shift_amt != '0)
                AST_LSL_LOW_CLEAR: assert ((opnd_out << (WIDTH - int'(shift_amt))) == '0) else $error("low bits not cleared"); // R1
            if (shift_kind == SHK_LSR && shift_amt != '0)
                AST_LSR_TOP_CLEAR: assert (opnd_out[WIDTH-1] == 1'b0) else $error("top bit not cleared"); // R2
            if (shift_kind == SHK_ASR)
                AST_ASR_SIGN_KEPT: assert (opnd_out[WIDTH-1] == opnd_in[WIDTH-1]) else $error("sign lost"); // R3
            if (shift_kind == SHK_ROR)
                AST_ROR_ONES_KEPT: assert ($countones(opnd_out) == $countones(opnd_in)) else $error("rotate lost bits"); // R4
            if (shift_kind == SHK_RRX)
                AST_RRX_CARRY_PATH: assert (opnd_out[WIDTH-1] == carry_in && carry_out == opnd_in[0]) else $error("rrx carry path"); // R5
            if (shift_kind < 3'd4 && shift_amt == '0)
                AST_ZERO_PASS: assert (opnd_out == opnd_in && carry_out == carry_in) else $error("zero distance altered"); // R7
            if (shift_kind > 3'd4)
                AST_UNUSED_KIND_PASS: assert (opnd_out == opnd_in && carry_out == carry_in) else $error("unused kind altered"); // R8
        end
    end
endmodule

bind operand_shifter operand_shifter_checker #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_checker (
    .opnd_in    (opnd_in),
    .shift_kind (shift_kind),
    .shift_amt  (shift_amt),
    .carry_in   (carry_in),
    .opnd_out   (opnd_out),
    .carry_out  (carry_out)
);

// File: tb/operand_shifter_bench.sv
`timescale 1ns/1ps
// Bench for operand_shifter: directed corners plus seeded random sweep over
// every kind code and distance, against reference functions below.
module operand_shifter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_in = '0;
    logic [2:0]  shift_kind = '0;
    logic [4:0]  shift_amt = '0;
    logic        carry_in = 1'b0;
    logic [31:0] opnd_out;
    logic        carry_out;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    operand_shifter u_operand_shifter (
        .opnd_in    (opnd_in),
        .shift_kind (shift_kind),
        .shift_amt  (shift_amt),
        .carry_in   (carry_in),
        .opnd_out   (opnd_out),
        .carry_out  (carry_out)
    );

    function automatic logic [31:0] ref_out(logic [31:0] v, logic [2:0] k, int n, logic c);
        case (k)
            3'd0: return v << n;
            3'd1: return v >> n;
            3'd2: return 32'($signed(v) >>> n);
            3'd3: return (n == 0) ? v : ((v >> n) | (v << (32 - n)));
            3'd4: return {c, v[31:1]};
            default: return v;
        endcase
    endfunction

    function automatic logic ref_carry(logic [31:0] v, logic [2:0] k, int n, logic c);
        if (k == 3'd4) return v[0];
        if (k > 3'd4 || n == 0) return c;
        if (k == 3'd0) return v[32-n];
        return v[n-1];
    endfunction

    function automatic string req_of(logic [2:0] k, int n);
        if (k > 3'd4) return "R8";
        if (k == 3'd4) return "R5";
        if (n == 0) return "R7";
        case (k)
            3'd0: return "R1/R6";
            3'd1: return "R2/R6";
            3'd2: return "R3/R6";
            default: return "R4/R6";
        endcase
    endfunction

    task automatic apply_check(string tag, logic [31:0] v, logic [2:0] k, logic [4:0] n, logic c,
                               logic [31:0] exp_v, logic exp_c);
        @(posedge clk);
        opnd_in = v; shift_kind = k; shift_amt = n; carry_in = c;
        @(negedge clk);
        checks++;
        if (opnd_out !== exp_v || carry_out !== exp_c) begin
            errors++;
            $display("FAIL %s: kind=%0d amt=%0d in=%h cin=%b got %h/%b expected %h/%b",
                     tag, k, n, v, c, opnd_out, carry_out, exp_v, exp_c);
        end
    endtask

    initial begin
        void'($urandom(32'd20517));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle inputs: zero operand, left shift by zero, carry clear (R7).
        apply_check("R7 idle", 32'h0, 3'd0, 5'd0, 1'b0, 32'h0, 1'b0);
        // Directed corners.
        apply_check("R1 msb out", 32'h8000_0001, 3'd0, 5'd1, 1'b0, 32'h0000_0002, 1'b1);
        apply_check("R2 lsb out", 32'h0000_0001, 3'd1, 5'd1, 1'b0, 32'h0000_0000, 1'b1);
        apply_check("R3 far sign", 32'h8000_0000, 3'd2, 5'd31, 1'b1, 32'hFFFF_FFFF, 1'b0);
        apply_check("R4 left rot 4", 32'h1234_5678, 3'd3, 5'd28, 1'b0, 32'h2345_6781, 1'b0);
        apply_check("R4 rot 1", 32'h0000_0001, 3'd3, 5'd1, 1'b0, 32'h8000_0000, 1'b1);
        apply_check("R5 cin in", 32'h0000_0001, 3'd4, 5'd0, 1'b1, 32'h8000_0000, 1'b1);
        apply_check("R5 amt ignored", 32'h0000_0001, 3'd4, 5'd17, 1'b1, 32'h8000_0000, 1'b1);
        apply_check("R5 cin clear", 32'hFFFF_FFFE, 3'd4, 5'd9, 1'b0, 32'h7FFF_FFFF, 1'b0);
        apply_check("R6 lsl 31", 32'h0000_0002, 3'd0, 5'd31, 1'b0, 32'h0000_0000, 1'b1);
        apply_check("R7 zero carry", 32'hA5A5_5A5A, 3'd2, 5'd0, 1'b1, 32'hA5A5_5A5A, 1'b1);
        apply_check("R8 code 6", 32'hDEAD_BEEF, 3'd6, 5'd5, 1'b1, 32'hDEAD_BEEF, 1'b1);
        // Seeded random sweep over all kinds and distances.
        for (int k = 0; k < 8; k++) begin
            for (int n = 0; n < 32; n++) begin
                for (int r = 0; r < 6; r++) begin
                    logic [31:0] v;
                    logic        c;
                    v = $urandom();
                    c = 1'($urandom());
                    apply_check(req_of(3'(k), n), v, 3'(k), 5'(n), c,
                                ref_out(v, 3'(k), n, c), ref_carry(v, 3'(k), n, c));
                end
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule